// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Gate

This block sits between the clock generators of a clocking chip and its output pins. It receives three already running source clocks: a CPU-rate clock, a PCI-rate clock and a 48 MHz clock. From these it drives a set of outputs:

- single-ended CPU clocks;
- one differential CPU pair;
- a free-running PCI clock and a bank of stoppable PCI clocks;
- a fixed 48 MHz output;
- a selectable 24/48 MHz output.

Each output can be stopped by the stop pins that apply to it, by its own enable bit, and by a qualified power-down request. It stops and restarts only while its source clock is low, so no shortened pulse ever reaches a pin.

Power-down is qualified by a four-state machine clocked on the CPU clock. The states are:

- `PD_RUN`: normal operation.
- `PD_ARM`: one low sample of the power-down pin has been seen.
- `PD_DOWN`: power-down is qualified and in force.
- `PD_WAKE`: one high sample has been seen while down.

The transitions are:

- `PD_RUN` → `PD_ARM` on a low sample.
- `PD_ARM` → `PD_DOWN` on a second low sample.
- `PD_ARM` → `PD_RUN` on a high sample.
- `PD_DOWN` → `PD_WAKE` on a high sample.
- `PD_WAKE` → `PD_RUN` on a second high sample.
- `PD_WAKE` → `PD_DOWN` on a low sample.

The status output is high in `PD_DOWN` and `PD_WAKE`. Each output has a gate cell: a short synchroniser clocked on the falling edge of that output's own source clock, which moves the run request into a clean enable. The pin is the source clock ANDed with that enable.

Top module: `clk_stop_gate`

## Requirements
- R1: Power-down becomes active only after `pd_n` is sampled low on two consecutive rising edges of `clk_cpu`. A low level seen at a single edge leaves `pd_active` at 0 and every output running.
- R2: Once power-down is active, every output stops at a low level and `pd_active` reads 1. For the pair, `cpu_pair_t` is held low and `cpu_pair_c` is held high. CPU outputs whose free-running bit is 1 stop as well.
- R3: After power-down, `pd_active` clears only once `pd_n` has been sampled high on two consecutive rising edges of `clk_cpu`. Every enabled output then runs again.
- R4: While `cpu_stop_n` is 0, each CPU output whose free-running bit is 0 stops low. The pair stops with true low and complement high. CPU bit order is: bit 0 = `cpu_out[0]`, bit 1 = `cpu_out[1]`, bit 2 = the pair.
- R5: A CPU output whose free-running bit is 1 keeps running while `cpu_stop_n` is 0.
- R6: While `pci_stop_n` is 0, every `pci_out` bit stops low. `pci_free_out` and all non-PCI outputs keep running.
- R7: An output whose enable bit is 0 is held low, or high for `cpu_pair_c`. Outputs with their enable at 1 are unaffected. Enable bits use 1 for run.
- R8: `aux_out` runs at the `clk_48` rate when `aux_sel48` is 1. It runs at half that rate when `aux_sel48` is 0.
- R9: While `rst_n` is 0, every output is low except `cpu_pair_c`, which is high, and `pd_active` is 0.
- R10: Stopping or restarting never produces a high pulse on an output shorter than the high phase of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU-rate source clock; also clocks the power-down qualifier |
| clk_pci | input | 1 | PCI-rate source clock |
| clk_48 | input | 1 | 48 MHz source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down request |
| cpu_stop_n | input | 1 | Active-low stop for CPU outputs |
| pci_stop_n | input | 1 | Active-low stop for the stoppable PCI outputs |
| cpu_en | input | NCPU_SE+1 | Enable per CPU output (bit NCPU_SE = pair) |
| cpu_free | input | NCPU_SE+1 | Free-running bit per CPU output (1 = ignores cpu_stop_n) |
| pci_free_en | input | 1 | Enable for the free-running PCI output |
| pci_en | input | NPCI | Enable per stoppable PCI output |
| usb_en | input | 1 | Enable for the 48 MHz output |
| aux_en | input | 1 | Enable for the 24/48 MHz output |
| aux_sel48 | input | 1 | 1 = 48 MHz, 0 = 24 MHz on aux_out |
| cpu_out | output | NCPU_SE | Gated single-ended CPU clocks |
| cpu_pair_t | output | 1 | Gated true side of the CPU pair |
| cpu_pair_c | output | 1 | Gated complement side of the CPU pair |
| pci_free_out | output | 1 | Gated free-running PCI clock |
| pci_out | output | NPCI | Gated stoppable PCI clocks |
| usb_out | output | 1 | Gated 48 MHz clock |
| aux_out | output | 1 | Gated 24/48 MHz clock |
| pd_active | output | 1 | Power-down status |

## Verification
A CPU stop and a qualified power-down can be in force in the same cycle, and they act on the same CPU gates. The bench holds `cpu_stop_n` low with the free-running bit set on `cpu_out[1]`, so that output is exempt from the stop. It then drives `pd_n` low for longer than the qualification window. `cpu_out[1]` must then also go low, because power-down overrides the free-running exemption. A further check, once both are released, confirms that the stop and the power-down release independently. Throughout this overlap a pulse-width monitor on `cpu_out[0]` and `pci_out[0]` counts any high pulse shorter than the source high phase.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ns/1ps
package clk_stop_gate_pkg;

    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_ARM  = 2'd1,
        PD_DOWN = 2'd2,
        PD_WAKE = 2'd3
    } pd_state_e;

endpackage

// File: rtl/pd_fsm.sv
`timescale 1ns/1ps
module pd_fsm
    import clk_stop_gate_pkg::*;
(
    input  logic clk_cpu,
    input  logic rst_n,
    input  logic pd_n,
    output logic pd_active
);

    pd_state_e state_q;
    pd_state_e state_d;

    // state register
    always_ff @(posedge clk_cpu or negedge rst_n) begin
        if (!rst_n) state_q <= PD_RUN;
        else        state_q <= state_d;
    end

    // next-state logic: two equal samples in a row are needed to move either way
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_RUN:  if (!pd_n) state_d = PD_ARM;
            PD_ARM:  state_d = pd_n ? PD_RUN : PD_DOWN;
            PD_DOWN: if (pd_n) state_d = PD_WAKE;
            PD_WAKE: state_d = pd_n ? PD_RUN : PD_DOWN;
            default: state_d = PD_RUN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PD_DOWN, PD_WAKE: pd_active = 1'b1;
            default:          pd_active = 1'b0;
        endcase
    end

endmodule

// File: rtl/gate_cell.sv
`timescale 1ns/1ps
module gate_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic run,
    output logic clk_out
);

    localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic [SW-1:0] sync_q;

    // falling-edge chain: the enable only changes while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= SW'({sync_q, run});
    end

    assign clk_out = clk_src & sync_q[SW-1];

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
    import clk_stop_gate_pkg::*;
#(
    parameter int NCPU_SE     = 2,
    parameter int NPCI        = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_cpu,
    input  logic                clk_pci,
    input  logic                clk_48,
    input  logic                rst_n,
    input  logic                pd_n,
    input  logic                cpu_stop_n,
    input  logic                pci_stop_n,
    input  logic [NCPU_SE:0]    cpu_en,
    input  logic [NCPU_SE:0]    cpu_free,
    input  logic                pci_free_en,
    input  logic [NPCI-1:0]     pci_en,
    input  logic                usb_en,
    input  logic                aux_en,
    input  logic                aux_sel48,
    output logic [NCPU_SE-1:0]  cpu_out,
    output logic                cpu_pair_t,
    output logic                cpu_pair_c,
    output logic                pci_free_out,
    output logic [NPCI-1:0]     pci_out,
    output logic                usb_out,
    output logic                aux_out,
    output logic                pd_active
);

    localparam int NCPU = NCPU_SE + 1;

    logic [NCPU-1:0] cpu_run;
    logic [NCPU-1:0] cpu_gated;
    logic [NPCI-1:0] pci_run;
    logic            pci_free_run;
    logic            usb_run;
    logic            aux_run;
    logic            clk_24_q;
    logic            aux_src;

    pd_fsm u_pd (
        .clk_cpu   (clk_cpu),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .pd_active (pd_active)
    );

    // run requests per output
    always_comb begin
        cpu_run      = cpu_en & {NCPU{~pd_active}} & ({NCPU{cpu_stop_n}} | cpu_free);
        pci_run      = pci_en & {NPCI{~pd_active & pci_stop_n}};
        pci_free_run = pci_free_en & ~pd_active;
        usb_run      = usb_en & ~pd_active;
        aux_run      = aux_en & ~pd_active;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCPU; gi++) begin : g_cpu
            gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
                .clk_src (clk_cpu),
                .rst_n   (rst_n),
                .run     (cpu_run[gi]),
                .clk_out (cpu_gated[gi])
            );
        end
        for (gi = 0; gi < NPCI; gi++) begin : g_pci
            gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
                .clk_src (clk_pci),
                .rst_n   (rst_n),
                .run     (pci_run[gi]),
                .clk_out (pci_out[gi])
            );
        end
    endgenerate

    assign cpu_out    = cpu_gated[NCPU_SE-1:0];
    assign cpu_pair_t = cpu_gated[NCPU-1];
    assign cpu_pair_c = ~cpu_gated[NCPU-1];

    gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_pci_free (
        .clk_src (clk_pci),
        .rst_n   (rst_n),
        .run     (pci_free_run),
        .clk_out (pci_free_out)
    );

    gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_usb (
        .clk_src (clk_48),
        .rst_n   (rst_n),
        .run     (usb_run),
        .clk_out (usb_out)
    );

    // half-rate source for the selectable output
    always_ff @(posedge clk_48 or negedge rst_n) begin
        if (!rst_n) clk_24_q <= 1'b0;
        else        clk_24_q <= ~clk_24_q;
    end

    assign aux_src = aux_sel48 ? clk_48 : clk_24_q;

    gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_aux (
        .clk_src (aux_src),
        .rst_n   (rst_n),
        .run     (aux_run),
        .clk_out (aux_out)
    );

endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
    parameter int NCPU_SE = 2,
    parameter int NPCI    = 6
) (
    input logic               clk_cpu,
    input logic               clk_pci,
    input logic               rst_n,
    input logic               pd_n,
    input logic               cpu_stop_n,
    input logic               pci_stop_n,
    input logic [NCPU_SE:0]   cpu_free,
    input logic [NCPU_SE-1:0] cpu_out,
    input logic               cpu_pair_t,
    input logic               cpu_pair_c,
    input logic [NPCI-1:0]    pci_out,
    input logic               pd_active
);

    logic [2:0] pd_cnt;
    logic [2:0] cstop_cnt;
    logic [2:0] pstop_cnt;

    always_ff @(posedge clk_cpu or negedge rst_n) begin
        if (!rst_n) begin
            pd_cnt    <= '0;
            cstop_cnt <= '0;
        end else begin
            pd_cnt    <= !pd_active ? 3'd0 : (pd_cnt == 3'd7 ? pd_cnt : pd_cnt + 3'd1);
            cstop_cnt <= (cpu_stop_n || cpu_free[0]) ? 3'd0
                         : (cstop_cnt == 3'd7 ? cstop_cnt : cstop_cnt + 3'd1);
        end
    end

    always_ff @(posedge clk_pci or negedge rst_n) begin
        if (!rst_n) pstop_cnt <= '0;
        else        pstop_cnt <= pci_stop_n ? 3'd0
                                 : (pstop_cnt == 3'd7 ? pstop_cnt : pstop_cnt + 3'd1);
    end

    // R1: status rises only after two low samples in a row
    p_qualify_r1: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        $rose(pd_active) |-> ($past(!pd_n, 1) && $past(!pd_n, 2)));

    // R3: status clears only after two high samples in a row
    p_release_r3: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        $fell(pd_active) |-> ($past(pd_n, 1) && $past(pd_n, 2)));

    // R2: CPU outputs and pair parked during the source high phase once down
    p_pd_parked_r2: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        (pd_cnt >= 3'd4) |-> (cpu_out == '0 && !cpu_pair_t && cpu_pair_c));

    // R4: non-free CPU output 0 parked under a held CPU stop
    p_cpu_stop_r4: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        (cstop_cnt >= 3'd4) |-> !cpu_out[0]);

    // R6: stoppable PCI outputs parked under a held PCI stop
    p_pci_stop_r6: assert property (@(negedge clk_pci) disable iff (!rst_n)
        (pstop_cnt >= 3'd4) |-> (pci_out == '0));

endmodule

bind clk_stop_gate clk_stop_gate_chk #(.NCPU_SE(NCPU_SE), .NPCI(NPCI)) u_chk (
    .clk_cpu    (clk_cpu),
    .clk_pci    (clk_pci),
    .rst_n      (rst_n),
    .pd_n       (pd_n),
    .cpu_stop_n (cpu_stop_n),
    .pci_stop_n (pci_stop_n),
    .cpu_free   (cpu_free),
    .cpu_out    (cpu_out),
    .cpu_pair_t (cpu_pair_t),
    .cpu_pair_c (cpu_pair_c),
    .pci_out    (pci_out),
    .pd_active  (pd_active)
);

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/1ps
module clk_stop_gate_test;

    localparam int NCPU_SE = 2;
    localparam int NPCI    = 6;

    // signal ids for the scoreboard
    localparam int S_CPU0 = 0, S_CPU1 = 1, S_PT = 2, S_PC = 3, S_PFREE = 4,
                   S_PCI0 = 5, S_PCIL = 6, S_USB = 7, S_AUXN = 8, S_PD = 9;

    logic clk_cpu = 0, clk_pci = 0, clk_48 = 0;
    logic rst_n = 0, pd_n = 1, cpu_stop_n = 1, pci_stop_n = 1;
    logic [NCPU_SE:0] cpu_en = '1, cpu_free = '1;
    logic pci_free_en = 1;
    logic [NPCI-1:0] pci_en = '1;
    logic usb_en = 1, aux_en = 1, aux_sel48 = 1;
    logic [NCPU_SE-1:0] cpu_out;
    logic cpu_pair_t, cpu_pair_c, pci_free_out, usb_out, aux_out, pd_active;
    logic [NPCI-1:0] pci_out;

    int checks = 0, failures = 0, pending = 0;
    int runt_cpu = 0, runt_pci = 0;
    realtime t_cpu_rise = 0, t_pci_rise = 0;

    typedef struct { string tag; int sig; int exp; } item_t;
    item_t q[$];

    always #4  clk_cpu = ~clk_cpu;      // 125 MHz
    initial begin #3; forever #15 clk_pci = ~clk_pci; end
    initial begin #1; forever #10 clk_48 = ~clk_48; end

    clk_stop_gate #(.NCPU_SE(NCPU_SE), .NPCI(NPCI), .SYNC_STAGES(2)) uut (
        .clk_cpu(clk_cpu), .clk_pci(clk_pci), .clk_48(clk_48), .rst_n(rst_n),
        .pd_n(pd_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_en(cpu_en), .cpu_free(cpu_free), .pci_free_en(pci_free_en),
        .pci_en(pci_en), .usb_en(usb_en), .aux_en(aux_en), .aux_sel48(aux_sel48),
        .cpu_out(cpu_out), .cpu_pair_t(cpu_pair_t), .cpu_pair_c(cpu_pair_c),
        .pci_free_out(pci_free_out), .pci_out(pci_out), .usb_out(usb_out),
        .aux_out(aux_out), .pd_active(pd_active)
    );

    // R10 pulse-width monitors
    always @(posedge cpu_out[0]) t_cpu_rise = $realtime;
    always @(negedge cpu_out[0]) if (rst_n && ($realtime - t_cpu_rise) < 3.9) runt_cpu++;
    always @(posedge pci_out[0]) t_pci_rise = $realtime;
    always @(negedge pci_out[0]) if (rst_n && ($realtime - t_pci_rise) < 14.9) runt_pci++;

    // sample a signal in the middle of its source clock high phase
    task automatic sample(input int sig, output int v);
        case (sig)
            S_CPU0, S_CPU1, S_PT, S_PC: begin
                @(posedge clk_cpu); #2;
                case (sig)
                    S_CPU0:  v = cpu_out[0];
                    S_CPU1:  v = cpu_out[1];
                    S_PT:    v = cpu_pair_t;
                    default: v = cpu_pair_c;
                endcase
            end
            S_PFREE, S_PCI0, S_PCIL: begin
                @(posedge clk_pci); #7;
                v = (sig == S_PFREE) ? pci_free_out : (sig == S_PCI0) ? pci_out[0] : pci_out[NPCI-1];
            end
            S_USB: begin @(posedge clk_48); #5; v = usb_out; end
            S_AUXN: begin
                v = 0;
                for (int k = 0; k < 8; k++) begin
                    @(posedge clk_48); #5;
                    if (aux_out) v++;
                end
            end
            default: begin #1; v = pd_active; end
        endcase
    endtask

    // monitor: pops expected items and compares
    initial begin
        forever begin
            int v;
            item_t it;
            wait (pending != 0);
            it = q[0];
            sample(it.sig, v);
            checks++;
            if (v != it.exp) begin
                failures++;
                $display("FAIL %s sig=%0d actual=%0d expected=%0d", it.tag, it.sig, v, it.exp);
            end
            void'(q.pop_front());
            pending--;
        end
    end

    // driver side: push an expectation and wait for it to be judged
    task automatic expect_sig(input string tag, input int sig, input int exp);
        item_t it;
        it.tag = tag; it.sig = sig; it.exp = exp;
        q.push_back(it);
        pending++;
        wait (pending == 0);
    endtask

    task automatic settle(input int ns);
        #(ns);
        @(negedge clk_cpu); #1;
    endtask

    initial begin
        #1_000_000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R9: reset state
        settle(40);
        expect_sig("R9", S_CPU0, 0);
        expect_sig("R9", S_PC, 1);
        expect_sig("R9", S_PFREE, 0);
        expect_sig("R9", S_PD, 0);
        rst_n = 1;
        cpu_free = '0;
        settle(200);
        expect_sig("R7", S_CPU0, 1);
        expect_sig("R7", S_PT, 1);
        expect_sig("R7", S_PC, 0);
        expect_sig("R7", S_PCI0, 1);
        expect_sig("R7", S_USB, 1);

        // R8: rate select
        aux_sel48 = 1; settle(200);
        expect_sig("R8", S_AUXN, 8);
        aux_sel48 = 0; settle(200);
        expect_sig("R8", S_AUXN, 4);

        // R1: a single low sample is ignored
        @(negedge clk_cpu); pd_n = 0;
        @(negedge clk_cpu); pd_n = 1;
        settle(200);
        expect_sig("R1", S_PD, 0);
        expect_sig("R1", S_CPU0, 1);
        expect_sig("R1", S_PCI0, 1);

        // R5 then R2: overlap of CPU stop (cpu_out[1] free) and power-down
        cpu_free = 3'b010;
        cpu_stop_n = 0;
        settle(200);
        expect_sig("R4", S_CPU0, 0);
        expect_sig("R4", S_PT, 0);
        expect_sig("R4", S_PC, 1);
        expect_sig("R5", S_CPU1, 1);
        pd_n = 0;
        settle(400);
        expect_sig("R2", S_PD, 1);
        expect_sig("R2", S_CPU1, 0);
        expect_sig("R2", S_PT, 0);
        expect_sig("R2", S_PC, 1);
        expect_sig("R2", S_PFREE, 0);
        expect_sig("R2", S_PCI0, 0);
        expect_sig("R2", S_USB, 0);
        expect_sig("R2", S_AUXN, 0);

        // R3: release
        cpu_stop_n = 1;
        @(negedge clk_cpu); pd_n = 1;
        @(negedge clk_cpu); pd_n = 0;   // single high sample: stays down
        settle(200);
        expect_sig("R3", S_PD, 1);
        expect_sig("R3", S_CPU0, 0);
        pd_n = 1;
        settle(400);
        expect_sig("R3", S_PD, 0);
        expect_sig("R3", S_CPU0, 1);
        expect_sig("R3", S_CPU1, 1);
        expect_sig("R3", S_PCI0, 1);
        expect_sig("R3", S_USB, 1);

        // R6: PCI stop
        pci_stop_n = 0;
        settle(300);
        expect_sig("R6", S_PCI0, 0);
        expect_sig("R6", S_PCIL, 0);
        expect_sig("R6", S_PFREE, 1);
        expect_sig("R6", S_CPU0, 1);
        pci_stop_n = 1;
        settle(300);
        expect_sig("R6", S_PCIL, 1);

        // R7: per-output enables
        cpu_en = 3'b010; usb_en = 0;
        settle(300);
        expect_sig("R7", S_CPU0, 0);
        expect_sig("R7", S_PC, 1);
        expect_sig("R7", S_CPU1, 1);
        expect_sig("R7", S_USB, 0);
        expect_sig("R7", S_PFREE, 1);
        cpu_en = '1; usb_en = 1;
        settle(300);
        expect_sig("R7", S_CPU0, 1);

        // R10: no runt pulses through every stop and restart above
        checks++;
        if (runt_cpu != 0) begin
            failures++;
            $display("FAIL R10 cpu runts actual=%0d expected=0", runt_cpu);
        end
        checks++;
        if (runt_pci != 0) begin
            failures++;
            $display("FAIL R10 pci runts actual=%0d expected=0", runt_pci);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule